// File: doc/BRIEF.md
# Threshold-Clipped Logistic Map Generator

This block iterates the chaotic map f(x) = 4x(1 − x) in unsigned fixed point, one step for each clock on which the step enable is high. After each step the map result is compared with a programmable ceiling. A result above the ceiling is replaced by the ceiling itself. This clamp pins the trajectory to a superstable periodic orbit, and the orbit length depends only on the ceiling value. A low ceiling gives a fixed point. Higher ceilings give orbits of length 2, 3, 4 and so on.

Each clamp produces a one-cycle pulse on a flag output. The block counts the steps between consecutive clamps and reports that count as the orbit period once two successive gaps agree. A synchronous load writes a seed value into the state and restarts the measurement. Any change of the ceiling also restarts the measurement. A long stretch with no clamp drops the period output back to zero, which means unlocked. A typical use is a small deterministic pattern source whose periodicity is selected by one register value.

Top module: `logmap_clip_gen`

## Requirements
- R1: State and ceiling are unsigned Q0.16, where code c means c/65536. A step computes floor(x·(65536 − x)/16384) from state code x. For example, 0x4000 maps to 0xC000.
- R2: A map result of 65536, reached only from x = 0x8000, saturates to 0xFFFF.
- R3: When a step's map result is strictly greater than the ceiling, the state takes the ceiling value and clip_o is high in the following cycle. Otherwise the state takes the map result and clip_o is low in the following cycle.
- R4: With step_i and load_i both low, the state holds and clip_o is low in the following cycle.
- R5: load_i writes seed_i into the state on the next edge and takes priority over step_i, so no map and no clamp happen in that cycle. period_o reads 0 after the load.
- R6: period_o reports the number of steps between consecutive clamps once two successive gaps are equal. When a gap differs from the one before it, period_o reads 0.
- R7: A ceiling below 0.75, for example 0x8000, locks to period 1.
- R8: A ceiling of 0.8 (0xCCCD) locks to period 2. A ceiling of 0.915 (0xEA3D) locks to period 4.
- R9: A ceiling of 0.965 (0xF70A) locks to period 3.
- R10: When 64 consecutive steps pass without a clamp, period_o reads 0, and the next clamp only serves as a new reference point.
- R11: When thresh_i differs from its value in the previous cycle, period_o reads 0 in the next cycle. A clamp that happens in that same cycle becomes the first reference point of the new measurement.
- R12: During and after reset, the state is 0, clip_o is 0 and period_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Write the seed into the state and restart measurement |
| seed_i | input | 16 | Seed value, Q0.16 |
| thresh_i | input | 16 | Clamp ceiling, Q0.16 |
| step_i | input | 1 | Advance the map by one iteration |
| state_o | output | 16 | Current state, Q0.16 |
| clip_o | output | 1 | High for one cycle after a step that clamped |
| period_o | output | 7 | Measured orbit length, 0 when unlocked |

## Verification
A ceiling change and a clamping step can fall in the same cycle. The measurement then has to discard its old history and, at the same time, adopt that clamp as the new reference. The bench provokes this case by moving the ceiling from 0x8000 to 0xCCCD while stepping from state 0x8000, whose map result 0xFFFF clamps. It then expects period_o to stay 0 for exactly three further steps and to read 2 after the fourth step. A behavioural model also compares all three outputs on every clock, including chaotic stretches in which clamps are rare.

// File: rtl/logmap_pkg.sv
package logmap_pkg;

  localparam int unsigned FRAC_W    = 16;
  localparam int unsigned GAP_LIMIT = 64;

  // progress of the orbit-length measurement
  typedef enum logic [1:0] {
    MEAS_IDLE   = 2'd0,   // no reference clamp yet
    MEAS_ANCHOR = 2'd1,   // one clamp seen, no gap recorded
    MEAS_TRACK  = 2'd2    // at least one gap recorded
  } meas_e;

endpackage

// File: rtl/logmap_core.sv
module logmap_core #(
  parameter int unsigned XW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [XW-1:0] seed_i,
  input  logic [XW-1:0] thresh_i,
  input  logic          step_i,
  output logic [XW-1:0] state_o,
  output logic          clip_o,
  output logic          clip_evt_o
);

  localparam int unsigned PRODW = 2 * XW + 1;

  // 4*x*(1-x) in Q0.XW; full-width product, then truncate, saturate 1.0
  function automatic logic [XW-1:0] map_step(input logic [XW-1:0] x);
    logic [XW:0]      comp;
    logic [PRODW-1:0] prod;
    logic [PRODW-1:0] quad;
    comp = {1'b1, {XW{1'b0}}} - {1'b0, x};
    prod = {{(XW+1){1'b0}}, x} * {{XW{1'b0}}, comp};
    quad = prod >> (XW - 2);
    if (quad[PRODW-1:XW] != '0) return '1;
    return quad[XW-1:0];
  endfunction

  logic [XW-1:0] state_q, state_d, mapped_w;
  logic          clip_q, over_w, clip_now_w;

  always_comb begin
    mapped_w   = map_step(state_q);
    over_w     = mapped_w > thresh_i;
    clip_now_w = step_i && !load_i && over_w;
    if (load_i)      state_d = seed_i;
    else if (step_i) state_d = over_w ? thresh_i : mapped_w;
    else             state_d = state_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= '0;
      clip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clip_q  <= clip_now_w;
    end
  end

  assign state_o    = state_q;
  assign clip_o     = clip_q;
  assign clip_evt_o = clip_now_w;

endmodule

// File: rtl/logmap_period.sv
module logmap_period #(
  parameter int unsigned MAX_GAP = 64,
  parameter int unsigned PW      = $clog2(MAX_GAP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clip_i,
  input  logic          restart_i,
  output logic [PW-1:0] period_o
);
  import logmap_pkg::*;

  localparam logic [PW-1:0] GAP_TOP = PW'(MAX_GAP);

  meas_e         mode_q;
  logic [PW-1:0] since_q, prev_q, period_q, gap_w;

  assign gap_w = (since_q == GAP_TOP) ? GAP_TOP : since_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q   <= MEAS_IDLE;
      since_q  <= '0;
      prev_q   <= '0;
      period_q <= '0;
    end else if (restart_i) begin
      mode_q   <= clip_i ? MEAS_ANCHOR : MEAS_IDLE;
      since_q  <= '0;
      prev_q   <= '0;
      period_q <= '0;
    end else if (step_i) begin
      if (clip_i) begin
        since_q <= '0;
        unique case (mode_q)
          MEAS_IDLE:   mode_q <= MEAS_ANCHOR;
          MEAS_ANCHOR: begin
            prev_q <= gap_w;
            mode_q <= MEAS_TRACK;
          end
          default: begin
            prev_q   <= gap_w;
            period_q <= (gap_w == prev_q) ? gap_w : '0;
          end
        endcase
      end else begin
        since_q <= gap_w;
        if (gap_w == GAP_TOP) begin
          period_q <= '0;
          mode_q   <= MEAS_IDLE;
        end
      end
    end
  end

  assign period_o = period_q;

endmodule

// File: rtl/logmap_clip_gen.sv
module logmap_clip_gen #(
  parameter int unsigned XW      = logmap_pkg::FRAC_W,
  parameter int unsigned MAX_GAP = logmap_pkg::GAP_LIMIT,
  localparam int unsigned PW     = $clog2(MAX_GAP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [XW-1:0] seed_i,
  input  logic [XW-1:0] thresh_i,
  input  logic          step_i,
  output logic [XW-1:0] state_o,
  output logic          clip_o,
  output logic [PW-1:0] period_o
);

  logic [XW-1:0] thresh_q;
  logic          thr_chg_w, restart_w, step_w, clip_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) thresh_q <= '0;
    else         thresh_q <= thresh_i;
  end

  assign thr_chg_w = thresh_i != thresh_q;
  assign restart_w = load_i || thr_chg_w;
  assign step_w    = step_i && !load_i;

  logmap_core #(.XW(XW)) core_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .seed_i     (seed_i),
    .thresh_i   (thresh_i),
    .step_i     (step_i),
    .state_o    (state_o),
    .clip_o     (clip_o),
    .clip_evt_o (clip_w)
  );

  logmap_period #(.MAX_GAP(MAX_GAP), .PW(PW)) period_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_w),
    .clip_i    (clip_w),
    .restart_i (restart_w),
    .period_o  (period_o)
  );

endmodule

// File: rtl/logmap_clip_gen_chk.sv
module logmap_clip_gen_chk #(
  parameter int unsigned XW      = 16,
  parameter int unsigned MAX_GAP = 64,
  parameter int unsigned PW      = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [XW-1:0] seed_i,
  input logic [XW-1:0] thresh_i,
  input logic          step_i,
  input logic [XW-1:0] state_o,
  input logic          clip_o,
  input logic [PW-1:0] period_o,
  input logic          restart_w,
  input logic          clip_w
);

  AST_CLIP_HOLDS_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clip_o |-> state_o == $past(thresh_i)); // R3

  AST_STEP_BELOW_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_o <= $past(thresh_i)); // R3

  AST_CLIP_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clip_w |=> clip_o); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(state_o) && !clip_o)); // R4

  AST_LOAD_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (state_o == $past(seed_i) && !clip_o && period_o == '0)); // R5

  AST_PERIOD_ON_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o != $past(period_o) && period_o != '0) |-> $past(clip_w)); // R6

  AST_PERIOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o <= PW'(MAX_GAP)); // R10

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_w |=> period_o == '0); // R11

endmodule

bind logmap_clip_gen logmap_clip_gen_chk #(.XW(XW), .MAX_GAP(MAX_GAP), .PW(PW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .seed_i    (seed_i),
  .thresh_i  (thresh_i),
  .step_i    (step_i),
  .state_o   (state_o),
  .clip_o    (clip_o),
  .period_o  (period_o),
  .restart_w (restart_w),
  .clip_w    (clip_w)
);

// File: tb/logmap_clip_gen_tb_top.sv
module logmap_clip_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, step = 1'b0;
  logic [15:0] seed = '0, thr = '0;
  logic [15:0] state;
  logic        clip;
  logic [6:0]  period;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_state = 0, m_clip = 0, m_period = 0, m_since = 0, m_mode = 0, m_prev = 0, m_thr = 0;

  always #10 clk = ~clk;

  logmap_clip_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed),
    .thresh_i(thr), .step_i(step), .state_o(state), .clip_o(clip), .period_o(period)
  );

  function automatic int ref_map(input int x);
    longint q;
    q = (longint'(x) * longint'(65536 - x)) / 16384;
    return (q > 65535) ? 65535 : int'(q);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit ld, input int sd, input int th, input bit st);
    bit chg, hit;
    int gap;
    chg = (th != m_thr);
    m_thr = th;
    hit = 0;
    if (ld) m_state = sd;
    else if (st) begin
      if (ref_map(m_state) > th) begin m_state = th; hit = 1; end
      else m_state = ref_map(m_state);
    end
    m_clip = hit;
    if (ld || chg) begin
      m_period = 0; m_since = 0; m_prev = 0; m_mode = hit ? 1 : 0;
    end else if (st) begin
      gap = (m_since + 1 > 64) ? 64 : m_since + 1;
      if (hit) begin
        m_since = 0;
        if (m_mode == 0) m_mode = 1;
        else if (m_mode == 1) begin m_prev = gap; m_mode = 2; end
        else begin m_period = (gap == m_prev) ? gap : 0; m_prev = gap; end
      end else begin
        m_since = gap;
        if (gap == 64) begin m_period = 0; m_mode = 0; end
      end
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit ld, input int sd, input int th, input bit st);
    load = ld; seed = 16'(sd); thr = 16'(th); step = st;
    @(posedge clk);
    model(ld, sd, th, st);
    @(negedge clk);
    chk("R1 R3 state vs model", int'(state), m_state);
    chk("R3 clip vs model", int'(clip), m_clip);
    chk("R6 R10 period vs model", int'(period), m_period);
  endtask

  task automatic run(input int n, input int th);
    for (int i = 0; i < n; i++) cyc(0, 0, th, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset state", int'(state), 0);
    chk("R12 reset clip", int'(clip), 0);
    chk("R12 reset period", int'(period), 0);
    rst_n = 1'b1;

    // R1: plain map step
    cyc(1, 16'h4000, 16'hFFFF, 0);
    cyc(0, 0, 16'hFFFF, 1);
    chk("R1 0x4000 maps to 0xC000", int'(state), 16'hC000);
    // R2: saturation of 1.0
    cyc(1, 16'h8000, 16'hFFFF, 0);
    cyc(0, 0, 16'hFFFF, 1);
    chk("R2 saturate to 0xFFFF", int'(state), 16'hFFFF);
    chk("R2 no clamp at ceiling", int'(clip), 0);
    // R4: idle holds
    cyc(0, 0, 16'hFFFF, 0);
    cyc(0, 0, 16'hFFFF, 0);
    chk("R4 idle holds state", int'(state), 16'hFFFF);
    // R3: clamp to ceiling
    cyc(1, 16'h4000, 16'h8000, 0);
    cyc(0, 0, 16'h8000, 1);
    chk("R3 clamped to ceiling", int'(state), 16'h8000);
    chk("R3 clip pulse", int'(clip), 1);
    cyc(0, 0, 16'h8000, 0);
    chk("R3 clip pulse ends", int'(clip), 0);
    // R7: fixed point
    run(6, 16'h8000);
    chk("R7 period 1", int'(period), 1);
    // R11: ceiling change together with a clamping step
    cyc(0, 0, 16'hCCCD, 1);
    chk("R11 restart on change", int'(period), 0);
    run(3, 16'hCCCD);
    chk("R11 still unlocked after 3 steps", int'(period), 0);
    run(1, 16'hCCCD);
    chk("R11 R8 period 2 after 4 steps", int'(period), 2);
    run(10, 16'hCCCD);
    chk("R8 period 2 holds", int'(period), 2);
    // R8: period 4
    run(30, 16'hEA3D);
    chk("R8 period 4", int'(period), 4);
    // R9: period 3
    run(30, 16'hF70A);
    chk("R9 period 3", int'(period), 3);
    chk("R6 period equals clamp gap", int'(period), 3);
    // R5: load beats step
    cyc(1, 16'h2000, 16'hF70A, 1);
    chk("R5 seed loaded", int'(state), 16'h2000);
    chk("R5 no clamp on load", int'(clip), 0);
    chk("R5 period cleared", int'(period), 0);
    // R10: long chaotic stretches, rare or no clamps
    cyc(1, 16'h1234, 16'hFFFF, 0);
    run(80, 16'hFFFF);
    chk("R10 no clamp means unlocked", int'(period), 0);
    cyc(1, 16'h1234, 16'hFF00, 0);
    run(400, 16'hFF00);
    cyc(1, 16'h0001, 16'hE000, 0);
    run(200, 16'hE000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule